// File: doc/BRIEF.md
# PWM Shadow Register Reload Controller

This block sits beside a PWM timer and owns the double-buffered copies of the timer's seven programmable values: six compare values and the initial count. Software writes new values into shadow storage at any time the block is not armed; the timer keeps running on the active copies. Software then arms a load-ok bit, and the block moves every shadow value into the active copies in one clock edge. The copy happens either immediately or at a qualifying reload point of the timer's period.

In reload-cycle mode, a reload opportunity is a full-cycle match pulse, a half-cycle match pulse, or either. A programmable divider turns every Nth opportunity into a reload cycle, with N from 1 to 16. Each reload cycle raises a reload flag, whether or not a load takes place. If unloaded shadow data is waiting but software never armed the load, the block raises a reload-error flag. A read-only flag shows that shadow data is waiting. Two interrupt enables share bit positions with the flags they gate and drive one interrupt line.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: A write (`wr_en`) with `wr_sel` 0..5 targets compare value 0..5 and with `wr_sel` 6 targets the initial count. Other `wr_sel` codes are dropped. A write changes only the shadow copy, and the active outputs keep their values until a load. Any write made while `ldok` is 1 is ignored.
- R2: With `mode_imm` = 1, a load takes place on the first clock edge at which `ldok` is already 1, with no match pulse needed. A one-cycle `ldok_set` strobe therefore produces new active values two edges after it is applied.
- R3: With `mode_imm` = 0, `full_match` counts as an opportunity only when `full_en` = 1, and `half_match` counts only when `half_en` = 1. Both pulses in the same cycle count as one opportunity. In immediate mode no opportunities are counted.
- R4: The frequency field written through `freq_wr`/`freq_data` holds N−1. A reload cycle happens on every Nth opportunity. The field is 0 after reset.
- R5: `ldok_set` sets `ldok`. A load clears it on the same edge. `ldok_clr` clears it without a load, blocks a load in the same cycle, and wins over `ldok_set`.
- R6: Status bit 12 (reload flag) is set by every reload cycle, regardless of `ldok`. Writing 1 to it through `sts_w1c_en`/`sts_w1c_data` clears it, and a new set in the same cycle wins.
- R7: Status bit 13 (reload error) is set when a reload cycle occurs while shadow data is unloaded and `ldok` is 0. It is cleared by writing 1. A reload cycle with `ldok` = 1 loads and does not set it.
- R8: Status bit 14 is 1 whenever an accepted write has not yet been loaded. It clears on the load edge and ignores status writes. All other status bits read 0.
- R9: `irq_en` keeps only bits 12 and 13 of the value written through `ien_wr`; all other bits read 0. `irq` is 1 while any status flag has its matching enable set.
- R10: The opportunity counter restarts from zero after every reload cycle and on every frequency-field write.
- R11: `load_strobe` is 1 for exactly the cycle in which the active outputs first show the loaded values. A reload cycle with `ldok` = 1 performs a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Shadow write strobe |
| wr_sel | input | 3 | Shadow slot select (0..5 compare, 6 initial count) |
| wr_data | input | 16 | Shadow write data |
| ldok_set | input | 1 | Arm load-ok |
| ldok_clr | input | 1 | Drop load-ok without loading |
| mode_imm | input | 1 | 1 = immediate load, 0 = reload-cycle load |
| full_en | input | 1 | Full-cycle matches are opportunities |
| half_en | input | 1 | Half-cycle matches are opportunities |
| freq_wr | input | 1 | Frequency field write strobe |
| freq_data | input | 4 | Frequency field value (N−1) |
| full_match | input | 1 | Full-cycle match pulse from the timer |
| half_match | input | 1 | Half-cycle match pulse from the timer |
| sts_w1c_en | input | 1 | Status write-1-to-clear strobe |
| sts_w1c_data | input | 16 | Status bits to clear |
| ien_wr | input | 1 | Interrupt-enable write strobe |
| ien_data | input | 16 | Interrupt-enable write data |
| act_cmp | output | 96 | Active compare values, value k at bits [16k+15:16k] |
| act_init | output | 16 | Active initial count |
| load_strobe | output | 1 | Load happened; new active values visible |
| ldok | output | 1 | Load-ok state |
| status | output | 16 | Flags: 12 reload, 13 reload error, 14 shadow pending |
| irq_en | output | 16 | Interrupt enables at bits 12 and 13 |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: 16-bit values, six compare slots and a 4-bit frequency field. With these values every slot select, including the initial count slot and an out-of-range code, can be driven directly. Divider ratios of 1, 2 and 3 are exercised; they cover the restart of the opportunity count, its reset by a field write, and the every-Nth behaviour without long pulse trains. The same settings reach the flag interplay: a missed load that raises the error, an armed reload that does not, and interrupt gating by each enable.

// File: rtl/prl_pkg.sv
// Shared constants for the PWM shadow reload controller.
// Assumes a 16-bit status / enable register view.
package prl_pkg;
    localparam int STS_W      = 16;
    localparam int STS_RELOAD = 12;
    localparam int STS_ERR    = 13;
    localparam int STS_UPD    = 14;
    localparam logic [STS_W-1:0] FLAG_MASK =
        (STS_W'(1) << STS_RELOAD) | (STS_W'(1) << STS_ERR);
endpackage

// File: rtl/prl_shadow_bank.sv
// Shadow and active storage for all programmable slots.
// Accepts writes only while unlocked; copies every shadow to active on load.
// Assumes load and an accepted write never coincide (lock is high on load).
module prl_shadow_bank #(
    parameter int DATA_W = 16,
    parameter int SLOTS  = 7,
    parameter int SEL_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    lock,
    input  logic                    load,
    output logic [SLOTS*DATA_W-1:0] act_flat,
    output logic                    pending
);
    logic accept;

    // Purpose: qualify a write against lock and a valid slot code.
    always_comb begin
        accept = wr_en && !lock && ({1'b0, wr_sel} < (SEL_W+1)'(SLOTS));
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] shadow_q;
        logic [DATA_W-1:0] active_q;

        // Purpose: capture an accepted write into this slot's shadow.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q <= '0;
            end else if (accept && (wr_sel == SEL_W'(g))) begin
                shadow_q <= wr_data;
            end
        end

        // Purpose: transfer the shadow to the active copy on load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active_q <= '0;
            end else if (load) begin
                active_q <= shadow_q;
            end
        end

        assign act_flat[g*DATA_W +: DATA_W] = active_q;
    end

    // Purpose: remember that some shadow holds data not yet loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (load) begin
            pending <= 1'b0;
        end else if (accept) begin
            pending <= 1'b1;
        end
    end
endmodule

// File: rtl/prl_opp_divider.sv
// Counts reload opportunities and marks every Nth one as a reload cycle.
// The field holds N-1; the count restarts on a reload cycle or a field write.
module prl_opp_divider #(
    parameter int FREQ_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opp,
    input  logic              freq_wr,
    input  logic [FREQ_W-1:0] freq_data,
    output logic              reload_cycle
);
    logic [FREQ_W-1:0] freq_q;
    logic [FREQ_W-1:0] cnt_q;

    // Purpose: hold the programmed divide value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= '0;
        end else if (freq_wr) begin
            freq_q <= freq_data;
        end
    end

    // Purpose: a reload cycle is the opportunity that reaches the limit.
    always_comb begin
        reload_cycle = opp && (cnt_q == freq_q);
    end

    // Purpose: advance or restart the opportunity count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (freq_wr || reload_cycle) begin
            cnt_q <= '0;
        end else if (opp) begin
            cnt_q <= cnt_q + FREQ_W'(1);
        end
    end
endmodule

// File: rtl/prl_status_unit.sv
// Reload / reload-error flags (write-1-to-clear), read-only pending flag,
// interrupt enables and the interrupt line. Set wins over clear.
module prl_status_unit
    import prl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_cycle,
    input  logic             pending,
    input  logic             ldok,
    input  logic             w1c_en,
    input  logic [STS_W-1:0] w1c_data,
    input  logic             ien_wr,
    input  logic [STS_W-1:0] ien_data,
    output logic [STS_W-1:0] status,
    output logic [STS_W-1:0] irq_en,
    output logic             irq
);
    logic [STS_W-1:0] flag_q;
    logic [STS_W-1:0] ien_q;
    logic [STS_W-1:0] set_v;
    logic [STS_W-1:0] clr_v;

    // Purpose: form this cycle's flag set and clear vectors.
    always_comb begin
        set_v             = '0;
        set_v[STS_RELOAD] = reload_cycle;
        set_v[STS_ERR]    = reload_cycle && pending && !ldok;
        clr_v             = w1c_en ? w1c_data : '0;
    end

    // Purpose: update sticky flags, keeping only the defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= ((flag_q & ~clr_v) | set_v) & FLAG_MASK;
        end
    end

    // Purpose: store interrupt enables at the flag positions only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (ien_wr) begin
            ien_q <= ien_data & FLAG_MASK;
        end
    end

    // Purpose: present status, enables and the combined interrupt.
    always_comb begin
        status          = flag_q;
        status[STS_UPD] = pending;
        irq_en          = ien_q;
        irq             = |(flag_q & ien_q);
    end
endmodule

// File: rtl/pwm_reload_ctrl.sv
// Top of the PWM shadow reload controller. Owns the load-ok state, picks
// reload opportunities from the match pulses and issues the load.
// Assumes match pulses and strobes are single-cycle and synchronous to clk.
module pwm_reload_ctrl
    import prl_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_CMP = 6,
    parameter int FREQ_W  = 4,
    localparam int SLOTS  = NUM_CMP + 1,
    localparam int SEL_W  = $clog2(SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      ldok_set,
    input  logic                      ldok_clr,
    input  logic                      mode_imm,
    input  logic                      full_en,
    input  logic                      half_en,
    input  logic                      freq_wr,
    input  logic [FREQ_W-1:0]         freq_data,
    input  logic                      full_match,
    input  logic                      half_match,
    input  logic                      sts_w1c_en,
    input  logic [STS_W-1:0]          sts_w1c_data,
    input  logic                      ien_wr,
    input  logic [STS_W-1:0]          ien_data,
    output logic [NUM_CMP*DATA_W-1:0] act_cmp,
    output logic [DATA_W-1:0]         act_init,
    output logic                      load_strobe,
    output logic                      ldok,
    output logic [STS_W-1:0]          status,
    output logic [STS_W-1:0]          irq_en,
    output logic                      irq
);
    logic                    ldok_q;
    logic                    opp;
    logic                    reload_cycle;
    logic                    load_fire;
    logic                    pending;
    logic                    strobe_q;
    logic [SLOTS*DATA_W-1:0] act_flat;

    // Purpose: decide whether this cycle is an opportunity and a load.
    always_comb begin
        opp       = !mode_imm && ((full_en && full_match) || (half_en && half_match));
        load_fire = ldok_q && !ldok_clr && (mode_imm || reload_cycle);
    end

    // Purpose: load-ok handshake; clear strobe beats set, set beats load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldok_q <= 1'b0;
        end else if (ldok_clr) begin
            ldok_q <= 1'b0;
        end else if (ldok_set) begin
            ldok_q <= 1'b1;
        end else if (load_fire) begin
            ldok_q <= 1'b0;
        end
    end

    // Purpose: flag the cycle in which loaded values first appear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= load_fire;
        end
    end

    prl_shadow_bank #(
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS),
        .SEL_W  (SEL_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .lock     (ldok_q),
        .load     (load_fire),
        .act_flat (act_flat),
        .pending  (pending)
    );

    prl_opp_divider #(
        .FREQ_W (FREQ_W)
    ) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .opp          (opp),
        .freq_wr      (freq_wr),
        .freq_data    (freq_data),
        .reload_cycle (reload_cycle)
    );

    prl_status_unit u_sts (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_cycle (reload_cycle),
        .pending      (pending),
        .ldok         (ldok_q),
        .w1c_en       (sts_w1c_en),
        .w1c_data     (sts_w1c_data),
        .ien_wr       (ien_wr),
        .ien_data     (ien_data),
        .status       (status),
        .irq_en       (irq_en),
        .irq          (irq)
    );

    assign act_cmp     = act_flat[NUM_CMP*DATA_W-1:0];
    assign act_init    = act_flat[SLOTS*DATA_W-1 -: DATA_W];
    assign load_strobe = strobe_q;
    assign ldok        = ldok_q;
endmodule

// File: rtl/pwm_reload_ctrl_chk.sv
// Property checker for pwm_reload_ctrl, attached by bind below.
// Observes ports plus the divider's reload-cycle decision.
module pwm_reload_ctrl_chk #(
    parameter int DATA_W  = 16,
    parameter int NUM_CMP = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ldok,
    input logic                      ldok_set,
    input logic                      ldok_clr,
    input logic                      mode_imm,
    input logic                      load_strobe,
    input logic                      reload_cycle,
    input logic [2:0]                sts,
    input logic [NUM_CMP*DATA_W-1:0] act_cmp,
    input logic [DATA_W-1:0]         act_init
);
    // sts[0] reload flag, sts[1] reload error, sts[2] shadow pending

    a_r1_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe |-> $stable({act_init, act_cmp}));

    a_r2_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
        mode_imm && ldok && !ldok_clr |=> load_strobe);

    a_r5_ldok_drops: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe && !$past(ldok_set) |-> !ldok);

    a_r6_reload_flag: assert property (@(posedge clk) disable iff (!rst_n)
        reload_cycle |=> sts[0]);

    a_r7_error_flag: assert property (@(posedge clk) disable iff (!rst_n)
        reload_cycle && sts[2] && !ldok |=> sts[1]);

    a_r8_pending_clear: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |-> !sts[2]);
endmodule

bind pwm_reload_ctrl pwm_reload_ctrl_chk #(
    .DATA_W  (DATA_W),
    .NUM_CMP (NUM_CMP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ldok         (ldok),
    .ldok_set     (ldok_set),
    .ldok_clr     (ldok_clr),
    .mode_imm     (mode_imm),
    .load_strobe  (load_strobe),
    .reload_cycle (reload_cycle),
    .sts          (status[14:12]),
    .act_cmp      (act_cmp),
    .act_init     (act_init)
);

// File: tb/pwm_reload_ctrl_test.sv
module pwm_reload_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic        ldok_set, ldok_clr, mode_imm, full_en, half_en;
    logic        freq_wr;
    logic [3:0]  freq_data;
    logic        full_match, half_match;
    logic        sts_w1c_en;
    logic [15:0] sts_w1c_data;
    logic        ien_wr;
    logic [15:0] ien_data;
    logic [95:0] act_cmp;
    logic [15:0] act_init;
    logic        load_strobe, ldok, irq;
    logic [15:0] status, irq_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    pwm_reload_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ldok_set(ldok_set), .ldok_clr(ldok_clr), .mode_imm(mode_imm),
        .full_en(full_en), .half_en(half_en), .freq_wr(freq_wr), .freq_data(freq_data),
        .full_match(full_match), .half_match(half_match),
        .sts_w1c_en(sts_w1c_en), .sts_w1c_data(sts_w1c_data),
        .ien_wr(ien_wr), .ien_data(ien_data),
        .act_cmp(act_cmp), .act_init(act_init), .load_strobe(load_strobe),
        .ldok(ldok), .status(status), .irq_en(irq_en), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] cmp(input int k);
        return act_cmp[k*16 +: 16];
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic arm();
        ldok_set = 1'b1; tick(); ldok_set = 1'b0;
    endtask

    task automatic set_freq(input logic [3:0] f);
        freq_wr = 1'b1; freq_data = f; tick(); freq_wr = 1'b0;
    endtask

    task automatic clr_sts(input logic [15:0] m);
        sts_w1c_en = 1'b1; sts_w1c_data = m; tick(); sts_w1c_en = 1'b0;
    endtask

    task automatic pulse(input logic f, input logic h);
        full_match = f; half_match = h; tick();
        full_match = 1'b0; half_match = 1'b0;
    endtask

    task automatic t_reset();
        check("R5 reset ldok", ldok, 0);
        check("R8 reset status", status, 0);
        check("R1 reset active", {act_init, act_cmp[15:0]}, 0);
        check("R11 reset strobe", load_strobe, 0);
    endtask

    task automatic t_immediate();
        mode_imm = 1'b1;
        wr(3'd2, 16'h1234);
        check("R8 pending after write", status[14], 1);
        check("R1 active unchanged", cmp(2), 0);
        arm();
        check("R5 ldok set", ldok, 1);
        check("R2 not yet loaded", cmp(2), 0);
        tick();
        check("R2 immediate load", cmp(2), 16'h1234);
        check("R11 strobe", load_strobe, 1);
        check("R5 ldok cleared by load", ldok, 0);
        check("R8 pending cleared", status[14], 0);
        tick();
        check("R11 strobe one cycle", load_strobe, 0);
    endtask

    task automatic t_init_and_badsel();
        wr(3'd6, 16'hBEEF);
        wr(3'd7, 16'h0F0F);
        arm();
        tick();
        check("R1 init slot", act_init, 16'hBEEF);
        check("R1 bad select dropped", {cmp(0), cmp(1)}, 0);
    endtask

    task automatic t_locked();
        mode_imm = 1'b0; full_en = 1'b1; half_en = 1'b0;
        set_freq(4'd0);
        wr(3'd3, 16'hAAAA);
        arm();
        wr(3'd3, 16'h5555);
        pulse(1'b1, 1'b0);
        check("R1 write while armed ignored", cmp(3), 16'hAAAA);
        check("R11 reload with ldok loads", load_strobe, 1);
    endtask

    task automatic t_half();
        full_en = 1'b0; half_en = 1'b1;
        wr(3'd4, 16'h0444);
        arm();
        pulse(1'b1, 1'b0);
        check("R3 full ignored when disabled", ldok, 1);
        check("R3 no load from full", cmp(4), 0);
        pulse(1'b0, 1'b1);
        check("R3 half load", cmp(4), 16'h0444);
        half_en = 1'b0;
    endtask

    task automatic t_divider();
        full_en = 1'b1;
        set_freq(4'd2);
        wr(3'd5, 16'h0555);
        arm();
        pulse(1'b1, 1'b0); tick();
        pulse(1'b1, 1'b0); tick();
        check("R4 no load before Nth", cmp(5), 0);
        pulse(1'b1, 1'b0);
        check("R4 load on 3rd", cmp(5), 16'h0555);
        set_freq(4'd0);
    endtask

    task automatic t_ldok_clr();
        wr(3'd0, 16'h0A0A);
        arm();
        ldok_clr = 1'b1; full_match = 1'b1; tick();
        ldok_clr = 1'b0; full_match = 1'b0;
        check("R5 clear strobe", ldok, 0);
        check("R5 clear blocks load", cmp(0), 0);
        check("R8 still pending", status[14], 1);
    endtask

    task automatic t_error();
        clr_sts(16'h3000);
        pulse(1'b1, 1'b0);
        check("R6 reload flag", status[12], 1);
        check("R7 error flag", status[13], 1);
        check("R7 no load unarmed", cmp(0), 0);
        clr_sts(16'h1000);
        check("R6 w1c reload", status[13:12], 2'b10);
        clr_sts(16'h7000);
        check("R7 w1c error", status[13], 0);
        check("R8 read-only", status[14], 1);
        check("R8 other bits zero", status & 16'h8FFF, 0);
    endtask

    task automatic t_irq();
        pulse(1'b1, 1'b0);
        ien_wr = 1'b1; ien_data = 16'h2000; tick(); ien_wr = 1'b0;
        check("R9 irq on error", irq, 1);
        clr_sts(16'h2000);
        check("R9 irq gated", irq, 0);
        ien_wr = 1'b1; ien_data = 16'hFFFF; tick(); ien_wr = 1'b0;
        check("R9 enable bits", irq_en, 16'h3000);
        check("R9 irq on reload flag", irq, 1);
        ien_wr = 1'b1; ien_data = 16'h0000; tick(); ien_wr = 1'b0;
        clr_sts(16'h3000);
    endtask

    task automatic t_armed_reload();
        arm();
        pulse(1'b1, 1'b0);
        check("R11 load", cmp(0), 16'h0A0A);
        check("R7 no error when armed", status[13], 0);
        check("R6 flag when armed", status[12], 1);
    endtask

    task automatic t_restart();
        set_freq(4'd1);
        clr_sts(16'h1000);
        pulse(1'b1, 1'b0);
        set_freq(4'd1);
        pulse(1'b1, 1'b0);
        check("R10 count restarted", status[12], 0);
        pulse(1'b1, 1'b0);
        check("R10 reload after restart", status[12], 1);
    endtask

    task automatic t_both();
        half_en = 1'b1;
        clr_sts(16'h1000);
        pulse(1'b1, 1'b1);
        check("R3 coincident counts once", status[12], 0);
        pulse(1'b1, 1'b1);
        check("R3 second opportunity", status[12], 1);
        mode_imm = 1'b1;
        clr_sts(16'h1000);
        pulse(1'b1, 1'b1); pulse(1'b1, 1'b1);
        check("R3 none in immediate", status[12], 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; ldok_set = 0; ldok_clr = 0;
        mode_imm = 0; full_en = 0; half_en = 0; freq_wr = 0; freq_data = 0;
        full_match = 0; half_match = 0; sts_w1c_en = 0; sts_w1c_data = 0;
        ien_wr = 0; ien_data = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_immediate();
        t_init_and_badsel();
        t_locked();
        t_half();
        t_divider();
        t_ldok_clr();
        t_error();
        t_irq();
        t_armed_reload();
        t_restart();
        t_both();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule